// File: doc/BRIEF.md
# Fault Latch-Off and Auto-Retry Controller

This block owns the enable of a power switch once a fault has already been filtered and qualified upstream. It either keeps the switch off until software or the enable command re-arms it, or it recovers on its own. In recovery it alternates an off period with a short, bounded on period. After the on period it checks that the rail really came up and stays up. The mode input picks between these two policies at the moment a fault is taken.

In auto-retry mode every failed attempt doubles the off period (more exactly, shifts it left by a parameterised amount), up to a ceiling. A fault counter escalates to the latched-off state once a parameterised number of attempts has failed. An attempt counts as a success only when three conditions all hold: the rail-good flag is present at the end of the on period, it stays present for a full qualification window, and the current-in-window flag is true at the end of that window. A success clears the counter and restores the base off period.

The states are IDLE, RUN, COOLDOWN, ATTEMPT, QUALIFY and LATCHED. The transitions are:
- enable (IDLE→RUN)
- trip (RUN→LATCHED, or RUN→COOLDOWN)
- relaunch (COOLDOWN→ATTEMPT)
- rail-up (ATTEMPT→QUALIFY)
- success (QUALIFY→RUN)
- failure (ATTEMPT or QUALIFY→COOLDOWN, or →LATCHED at the cap)
- clear (LATCHED→IDLE)
- disable (any→IDLE)

Top module: `retry_ctrl`

## Requirements
- R1: After reset the state is IDLE, the switch enable and the latched flag are low and the attempt count is 0. In IDLE, a high enable command moves the block to RUN on the next clock.
- R2: The state output encodes IDLE=0, RUN=1, COOLDOWN=2, ATTEMPT=3, QUALIFY=4 and LATCHED=5. The switch enable is high exactly in RUN, ATTEMPT and QUALIFY, and the latched flag is high exactly in LATCHED.
- R3: The fault input has no effect in IDLE, COOLDOWN or LATCHED.
- R4: With mode_retry low, a fault in RUN moves the block to LATCHED on the next clock. It stays there until mcu_clear is high or the enable command goes low, and either of these leads to IDLE with the count cleared.
- R5: With mode_retry high, a fault in RUN starts COOLDOWN. COOLDOWN lasts the current off period in clocks (TOFF_BASE initially) and is followed by ATTEMPT for TON_RETRY clocks.
- R6: On the last ATTEMPT clock, rail_good high leads to QUALIFY and rail_good low is a failure.
- R7: QUALIFY lasts SUCCESS_TQUAL clocks. If rail_good holds throughout and cur_ok is high on the last clock, the block returns to RUN with the count at 0 and the off period back at TOFF_BASE.
- R8: A fault in ATTEMPT or QUALIFY, rail_good low during QUALIFY, or cur_ok low on the last QUALIFY clock is a failure. A fault on the last QUALIFY clock wins over success.
- R9: Each failure adds one to the count and shifts the off period left by BACKOFF_SHIFT, saturating at TOFF_MAX.
- R10: The failure that brings the count to NRETRY_MAX leads to LATCHED instead of COOLDOWN.
- R11: A low enable command leads to IDLE on the next clock from every state, ahead of any other transition. The switch enable is therefore low one clock later, and the count and off period are reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_cmd | input | 1 | Enable command |
| fault_q | input | 1 | Qualified fault |
| rail_good | input | 1 | Rail at or above its good level |
| cur_ok | input | 1 | Load current inside its window |
| mcu_clear | input | 1 | Software clear of the latched state |
| mode_retry | input | 1 | 1 = auto-retry, 0 = latch-off |
| sw_en | output | 1 | Power switch enable |
| state | output | 3 | Controller state code |
| retry_cnt | output | $clog2(NRETRY_MAX+1) | Failed attempts since last success |
| latched | output | 1 | Latched-off indication |

## Verification
Two pairs of events can land in the same cycle, and each pair is a question of priority.

The first pair is a new fault and the end of qualification. The bench raises the fault on exactly the last QUALIFY clock, with rail and current good, and expects COOLDOWN with the count incremented rather than RUN.

The second pair is a disable and a failure. The bench drops the enable command on the last ATTEMPT clock while the rail is low, and expects IDLE with a zero count rather than a new COOLDOWN. Each state is also timed clock by clock, so an off period that misses saturation or a timer that is off by one shows up as a state mismatch.

// File: rtl/rc_pkg.sv
package rc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RUN  = 3'd1,
        ST_COOL = 3'd2,
        ST_TRY  = 3'd3,
        ST_QUAL = 3'd4,
        ST_LOCK = 3'd5
    } rc_state_e;
endpackage

// File: rtl/rc_timer.sv
module rc_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/rc_backoff.sv
module rc_backoff #(
    parameter int CW        = 5,
    parameter int TOFF_BASE = 3,
    parameter int TOFF_MAX  = 20,
    parameter int SHIFT     = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restore,
    input  logic          grow,
    output logic [CW-1:0] off_q,
    output logic [CW-1:0] off_next
);
    localparam int WW = CW + SHIFT;
    logic [WW-1:0] wide;

    always_comb begin
        wide     = WW'(off_q) << SHIFT;
        off_next = (wide > WW'(TOFF_MAX)) ? CW'(TOFF_MAX) : wide[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restore)
            off_q <= CW'(TOFF_BASE);
        else if (grow)
            off_q <= off_next;
    end

    // R9: off period stays between base and ceiling
    assert_off_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (off_q >= CW'(TOFF_BASE)) && (off_q <= CW'(TOFF_MAX)));
    // R9: growth never shortens the off period
    assert_off_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grow && !restore) |=> (off_q >= $past(off_q)));
endmodule

// File: rtl/retry_ctrl.sv
module retry_ctrl
    import rc_pkg::*;
#(
    parameter int TON_RETRY     = 4,
    parameter int TOFF_BASE     = 3,
    parameter int TOFF_MAX      = 20,
    parameter int BACKOFF_SHIFT = 1,
    parameter int SUCCESS_TQUAL = 5,
    parameter int NRETRY_MAX    = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              en_cmd,
    input  logic                              fault_q,
    input  logic                              rail_good,
    input  logic                              cur_ok,
    input  logic                              mcu_clear,
    input  logic                              mode_retry,
    output logic                              sw_en,
    output logic [2:0]                        state,
    output logic [$clog2(NRETRY_MAX+1)-1:0]   retry_cnt,
    output logic                              latched
);
    localparam int MAXT_A = (TOFF_MAX > TON_RETRY) ? TOFF_MAX : TON_RETRY;
    localparam int MAXT   = (MAXT_A > SUCCESS_TQUAL) ? MAXT_A : SUCCESS_TQUAL;
    localparam int CW     = $clog2(MAXT + 1);
    localparam int NW     = $clog2(NRETRY_MAX + 1);

    rc_state_e     st, st_n;
    logic [NW-1:0] cnt, cnt_n, cnt_inc;
    logic          tmr_load, tmr_exp;
    logic [CW-1:0] tmr_val;
    logic          bo_restore, bo_grow, fail;
    logic [CW-1:0] off_q, off_next;

    rc_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_exp)
    );

    rc_backoff #(
        .CW(CW), .TOFF_BASE(TOFF_BASE), .TOFF_MAX(TOFF_MAX), .SHIFT(BACKOFF_SHIFT)
    ) u_backoff (
        .clk(clk), .rst_n(rst_n), .restore(bo_restore), .grow(bo_grow),
        .off_q(off_q), .off_next(off_next)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // next-state logic
    always_comb begin
        st_n       = st;
        cnt_n      = cnt;
        cnt_inc    = cnt + NW'(1);
        tmr_load   = 1'b0;
        tmr_val    = '0;
        bo_restore = 1'b0;
        bo_grow    = 1'b0;
        fail       = 1'b0;
        unique case (st)
            ST_IDLE: begin
                cnt_n      = '0;
                bo_restore = 1'b1;
                if (en_cmd) st_n = ST_RUN;
            end
            ST_RUN: begin
                if (fault_q) begin
                    if (mode_retry) begin
                        st_n     = ST_COOL;
                        tmr_load = 1'b1;
                        tmr_val  = off_q - CW'(1);
                    end else begin
                        st_n = ST_LOCK;
                    end
                end
            end
            ST_COOL: begin
                if (tmr_exp) begin
                    st_n     = ST_TRY;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(TON_RETRY - 1);
                end
            end
            ST_TRY: begin
                if (fault_q)
                    fail = 1'b1;
                else if (tmr_exp) begin
                    if (rail_good) begin
                        st_n     = ST_QUAL;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(SUCCESS_TQUAL - 1);
                    end else begin
                        fail = 1'b1;
                    end
                end
            end
            ST_QUAL: begin
                if (fault_q || !rail_good)
                    fail = 1'b1;
                else if (tmr_exp) begin
                    if (cur_ok) begin
                        st_n       = ST_RUN;
                        cnt_n      = '0;
                        bo_restore = 1'b1;
                    end else begin
                        fail = 1'b1;
                    end
                end
            end
            ST_LOCK: begin
                if (mcu_clear) begin
                    st_n       = ST_IDLE;
                    cnt_n      = '0;
                    bo_restore = 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase

        if (fail) begin
            cnt_n = cnt_inc;
            if (cnt_inc >= NW'(NRETRY_MAX)) begin
                st_n = ST_LOCK;
            end else begin
                st_n     = ST_COOL;
                bo_grow  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = off_next - CW'(1);
            end
        end

        if (!en_cmd) begin
            st_n       = ST_IDLE;
            cnt_n      = '0;
            bo_restore = 1'b1;
            bo_grow    = 1'b0;
        end
    end

    // output decode
    always_comb begin
        sw_en     = (st == ST_RUN) || (st == ST_TRY) || (st == ST_QUAL);
        latched   = (st == ST_LOCK);
        state     = st;
        retry_cnt = cnt;
    end

    // R11: disable removes switch drive within one clock
    assert_off_after_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_cmd |=> !sw_en);
    // R4: latch-off mode trip goes straight to the latched state
    assert_latch_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && en_cmd && fault_q && !mode_retry) |=> (st == ST_LOCK));
    // R4: latched state is held until a reset condition
    assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOCK && en_cmd && !mcu_clear) |=> (st == ST_LOCK));
    // R5: an attempt is only ever launched out of cooldown
    assert_try_after_cool_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TRY && $past(st) != ST_TRY) |-> ($past(st) == ST_COOL));
    // R8: rail loss in qualification never yields success
    assert_qual_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_QUAL && en_cmd && !rail_good) |=> (st != ST_RUN));
    // R10: attempt count never exceeds the cap
    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        retry_cnt <= NW'(NRETRY_MAX));
endmodule

// File: tb/tb_retry_ctrl.sv
`timescale 1ns/100ps
module tb_retry_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_cmd = 1'b0, fault_q = 1'b0, rail_good = 1'b0;
    logic       cur_ok = 1'b0, mcu_clear = 1'b0, mode_retry = 1'b0;
    logic       sw_en, latched;
    logic [2:0] state;
    logic [2:0] retry_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    retry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .en_cmd(en_cmd), .fault_q(fault_q),
        .rail_good(rail_good), .cur_ok(cur_ok), .mcu_clear(mcu_clear),
        .mode_retry(mode_retry), .sw_en(sw_en), .state(state),
        .retry_cnt(retry_cnt), .latched(latched)
    );

    // {en, fault, rail, cur, clr, mode, exp_state[2:0], exp_sw}
    localparam logic [9:0] VEC [0:15] = '{
        10'b1000000011, 10'b1000000011, 10'b1100001010, 10'b1000001010,
        10'b1100001010, 10'b1000100000, 10'b1000000011, 10'b0000000000,
        10'b0100000000, 10'b1000000011, 10'b1100001010, 10'b0000000000,
        10'b1000000011, 10'b1000010011, 10'b1100010100, 10'b0000000000
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_st(input logic [2:0] exp, input string tag);
        logic exp_sw, exp_l;
        exp_sw = (exp == 3'd1) || (exp == 3'd3) || (exp == 3'd4);
        exp_l  = (exp == 3'd5);
        n_chk++;
        if (state !== exp || sw_en !== exp_sw || latched !== exp_l) begin
            n_bad++;
            $display("FAIL %s: state/sw/latched = %0d/%0b/%0b expected %0d/%0b/%0b",
                     tag, state, sw_en, latched, exp, exp_sw, exp_l);
        end
    endtask

    task automatic expect_cnt(input int exp, input string tag);
        n_chk++;
        if (int'(retry_cnt) != exp) begin
            n_bad++;
            $display("FAIL %s: retry_cnt = %0d expected %0d", tag, retry_cnt, exp);
        end
    endtask

    task automatic hold(input logic [2:0] exp, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            expect_st(exp, tag);
            step();
        end
    endtask

    task automatic pulse_fault();
        fault_q = 1'b1;
        step();
        fault_q = 1'b0;
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        rst_n = 1'b1;
        // R1 reset state
        expect_st(3'd0, "R1 reset");
        expect_cnt(0, "R1 reset count");

        // table: R1 R2 R3 R4 R5 R11 in latch-off and retry modes
        for (int v = 0; v < 16; v++) begin
            en_cmd     = VEC[v][9];
            fault_q    = VEC[v][8];
            rail_good  = VEC[v][7];
            cur_ok     = VEC[v][6];
            mcu_clear  = VEC[v][5];
            mode_retry = VEC[v][4];
            step();
            expect_st(VEC[v][3:1], $sformatf("R2/R4 vector %0d", v));
        end
        fault_q = 0; mcu_clear = 0;

        // retry to cap, backoff and saturation
        mode_retry = 1; en_cmd = 1; rail_good = 0; cur_ok = 0;
        step();
        expect_st(3'd1, "R1 enable");
        pulse_fault();
        expect_st(3'd2, "R5 cooldown entry");
        pulse_fault();                       // R3 fault ignored in cooldown
        hold(3'd2, 2, "R3 cooldown unaffected");
        hold(3'd3, 4, "R5 attempt length");
        expect_cnt(1, "R6 fail-to-start count");
        hold(3'd2, 6, "R9 backoff 6");
        hold(3'd3, 4, "R6 attempt 2");
        expect_cnt(2, "R9 count 2");
        hold(3'd2, 12, "R9 backoff 12");
        hold(3'd3, 4, "R6 attempt 3");
        expect_cnt(3, "R9 count 3");
        hold(3'd2, 20, "R9 saturated off period");
        hold(3'd3, 4, "R6 attempt 4");
        expect_st(3'd5, "R10 cap latches");
        expect_cnt(4, "R10 cap count");
        pulse_fault();
        hold(3'd5, 2, "R3 fault ignored in latched");
        mcu_clear = 1; step(); mcu_clear = 0;
        expect_st(3'd0, "R4 clear to idle");
        expect_cnt(0, "R4 clear count");

        // success after one failure, base restored
        step();
        expect_st(3'd1, "R1 re-enable");
        pulse_fault();
        hold(3'd2, 3, "R5 base cooldown");
        hold(3'd3, 4, "R6 attempt fail");
        hold(3'd2, 6, "R9 grown cooldown");
        rail_good = 1; cur_ok = 1;
        hold(3'd3, 4, "R6 attempt rail up");
        hold(3'd4, 5, "R7 qualify length");
        expect_st(3'd1, "R7 success");
        expect_cnt(0, "R7 count cleared");
        pulse_fault();
        hold(3'd2, 3, "R7 base cooldown restored");

        // qualification failures
        cur_ok = 0;
        hold(3'd3, 4, "R6 attempt");
        hold(3'd4, 5, "R8 qualify cur low");
        expect_cnt(1, "R8 cur low fails");
        hold(3'd2, 6, "R9 cooldown 6");
        hold(3'd3, 4, "R6 attempt");
        expect_st(3'd4, "R8 qualify");
        step();
        rail_good = 0;
        expect_st(3'd4, "R8 qualify");
        step();
        expect_st(3'd2, "R8 rail drop fails");
        expect_cnt(2, "R8 rail drop count");
        rail_good = 1; cur_ok = 1;
        hold(3'd2, 12, "R9 cooldown 12");
        hold(3'd3, 4, "R6 attempt");
        hold(3'd4, 4, "R8 qualify");
        expect_st(3'd4, "R8 last qualify cycle");
        pulse_fault();
        expect_st(3'd2, "R8 fault beats success");
        expect_cnt(3, "R8 fault count");
        hold(3'd2, 20, "R9 saturated");
        expect_st(3'd3, "R8 attempt");
        pulse_fault();
        expect_st(3'd5, "R8 fault in attempt hits cap R10");
        en_cmd = 0; step();
        expect_st(3'd0, "R11 enable toggle clears latch");
        expect_cnt(0, "R11 count cleared");

        // disable collides with failure at attempt end
        en_cmd = 1; rail_good = 0;
        step();
        pulse_fault();
        hold(3'd2, 3, "R5 cooldown");
        hold(3'd3, 3, "R5 attempt");
        expect_st(3'd3, "R11 last attempt cycle");
        en_cmd = 0; step();
        expect_st(3'd0, "R11 disable beats failure");
        expect_cnt(0, "R11 disable count");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule